// File: doc/BRIEF.md
# USB Type-C CC Attach Decision Controller

This block sits beside the analog configuration-channel front end of a USB Type-C port. The front end reports a status byte for the two CC pins. The controller reads that byte on a strobe and decides whether a partner is present, and if so in which orientation and with which roles. The status byte carries a 2-bit code for each pin, plus a flag that says whether the local side currently presents a sink or a source termination. The controller reads each code against that flag. It then sorts the pair into one of five cases: detached, attached as source/host, attached as sink/device, audio-detached, or unrecognized.

From that decision the block drives several outputs: the pull-up/pull-down role byte, the orientation bit and its inverted superspeed mux select, and the message-header role byte. It also drives the receive-detect enables, VCONN, and the VBUS source and sink requests. When the port becomes detached, the controller restores dual-role toggling in the order chosen by the host-first preference input, and it pulses a look-for-connection request. Power Delivery messaging and the timing of a full Type-C state machine belong to other blocks.

Top module: `typec_cc_attach`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is detached. The role byte is 0x4A if `host_first` is 1 and 0x45 if it is 0. The orientation is 0, the message-header byte is 0x02, and the receive-detect byte is 0. VCONN, both VBUS requests, `attached`, `look_req` and `cc_err` are all 0. The stored last status is 0x00.
- R2: Each CC code is read against the termination flag in status bit 4. The CC1 code is in bits [1:0] and the CC2 code is in bits [3:2]. When bit 4 is 1 (local sink), code 0 means open and codes 1, 2 and 3 mean an Rp pull-up. When bit 4 is 0 (local source), code 1 means Ra, code 2 means Rd, and codes 0 and 3 mean open. Bits 5 to 7 have no effect.
- R3: If both pins are open, the port is detached. The receive-detect byte goes to 0. VCONN, source VBUS and sink VBUS go to 0. The orientation goes to 0 and `attached` goes to 0.
- R4: On detach, the role byte is written as 0x40 plus 0x0A when `host_first` is 1, or 0x40 plus 0x05 when it is 0. `look_req` is high for exactly that one cycle.
- R5: If exactly one pin reads Rd, the port attaches as source/host. The orientation is 1 if CC2 is the Rd pin and 0 otherwise. The receive-detect byte becomes 0x21, source VBUS becomes 1, sink VBUS becomes 0 and `attached` becomes 1. The role byte keeps its value.
- R6: On a source attach, VCONN is 1 only when the other pin reads Ra. Otherwise it is 0.
- R7: If one pin reads Rp and the other pin is open, the port attaches as sink/device. The orientation is 1 if CC1 is open and 0 otherwise. The role byte becomes 0x0E when CC1 carries Rp and 0x0B when CC2 carries Rp. Both VBUS requests go to 0 and `attached` becomes 1. The receive-detect byte and VCONN keep their values.
- R8: The message-header byte is 0x0B after a source attach and 0x02 after a sink attach. Bit 1 is always set, bit 0 marks the source power role and bit 3 marks the host data role.
- R9: `ss_sel` is always the inverse of `orient`.
- R10: A strobed status equal to the last processed status changes nothing, and `look_req` stays 0.
- R11: If one pin reads Ra and the other is open (audio detached), no output changes, but the status is stored as the last processed value.
- R12: Any other combination sets `cc_err`, which stays set until reset. No other output changes, and the last processed value is not updated.
- R13: Outputs change only at the clock edge that samples `cc_valid` high, and are visible from that edge on. Without a strobe, no output changes and `look_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_first | input | 1 | Toggling preference: 1 = try source/host first |
| cc_valid | input | 1 | Strobe qualifying `cc_stat` |
| cc_stat | input | 8 | CC status byte: CC1 [1:0], CC2 [3:2], local-sink flag [4] |
| role_ctrl | output | 8 | Pull-up/pull-down role byte; bit 6 = dual-role toggling |
| orient | output | 1 | Plug orientation: 0 = CC1, 1 = CC2 |
| ss_sel | output | 1 | Superspeed mux select, inverse of `orient` |
| hdr_role | output | 8 | Message-header role byte |
| rx_det | output | 8 | Receive-detect enables: bit 0 SOP, bit 5 hard reset |
| vconn_en | output | 1 | VCONN supply enable |
| src_vbus | output | 1 | Request to source VBUS at the default level |
| snk_vbus | output | 1 | Request to sink VBUS |
| look_req | output | 1 | One-cycle look-for-connection command |
| attached | output | 1 | Partner attached |
| cc_err | output | 1 | Sticky flag for an unrecognized CC combination |

## Verification
The properties assume that `cc_valid` and `cc_stat` are stable around the sampling edge, and that `host_first` only matters at a detach or during reset. The bench changes every input half a cycle away from the rising edge. Random status bytes are drawn over all 256 values, so both termination readings, error combinations and ignored upper bits all occur. They are mixed with repeats of the previous byte, idle gaps and random changes of the preference. A directed sequence covers each attach class, VCONN with and without Ra, and both orientations.

// File: rtl/typec_cc_attach.sv
module typec_cc_attach #(
  parameter logic [7:0] RX_ON     = 8'h21,
  parameter logic [7:0] HDR_BASE  = 8'h02,
  parameter logic [7:0] TOG_BIT   = 8'h40,
  parameter logic [7:0] PAT_HOST  = 8'h0A,
  parameter logic [7:0] PAT_DEV   = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_first,
  input  logic       cc_valid,
  input  logic [7:0] cc_stat,
  output logic [7:0] role_ctrl,
  output logic       orient,
  output logic       ss_sel,
  output logic [7:0] hdr_role,
  output logic [7:0] rx_det,
  output logic       vconn_en,
  output logic       src_vbus,
  output logic       snk_vbus,
  output logic       look_req,
  output logic       attached,
  output logic       cc_err
);
  localparam logic [1:0] T_OPEN = 2'd0;
  localparam logic [1:0] T_RA   = 2'd1;
  localparam logic [1:0] T_RD   = 2'd2;
  localparam logic [1:0] T_RP   = 2'd3;
  localparam logic [7:0] HDR_SRC  = HDR_BASE | 8'h09;
  localparam logic [7:0] SNK_CC1  = 8'h0E;
  localparam logic [7:0] SNK_CC2  = 8'h0B;

  function automatic logic [1:0] term_of(input logic [1:0] code, input logic local_snk);
    if (local_snk) return (code == 2'd0) ? T_OPEN : T_RP;
    case (code)
      2'd1:    return T_RA;
      2'd2:    return T_RD;
      default: return T_OPEN;
    endcase
  endfunction

  logic [7:0] last_stat;
  logic [1:0] t1, t2;
  logic       fresh, is_det, is_src, is_snk, is_aud;
  logic [7:0] tog_byte;

  assign t1     = term_of(cc_stat[1:0], cc_stat[4]);
  assign t2     = term_of(cc_stat[3:2], cc_stat[4]);
  assign fresh  = cc_valid && (cc_stat != last_stat);
  assign is_det = (t1 == T_OPEN) && (t2 == T_OPEN);
  assign is_src = (t1 == T_RD) != (t2 == T_RD);
  assign is_snk = ((t1 == T_RP) && (t2 == T_OPEN)) || ((t2 == T_RP) && (t1 == T_OPEN));
  assign is_aud = ((t1 == T_RA) && (t2 == T_OPEN)) || ((t2 == T_RA) && (t1 == T_OPEN));
  assign tog_byte = TOG_BIT | (host_first ? PAT_HOST : PAT_DEV);
  assign ss_sel = ~orient;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_ctrl <= tog_byte;
      orient    <= 1'b0;
      hdr_role  <= HDR_BASE;
      rx_det    <= 8'h00;
      vconn_en  <= 1'b0;
      src_vbus  <= 1'b0;
      snk_vbus  <= 1'b0;
      look_req  <= 1'b0;
      attached  <= 1'b0;
      cc_err    <= 1'b0;
      last_stat <= 8'h00;
    end else begin
      look_req <= 1'b0;
      if (fresh) begin
        if (is_det) begin
          rx_det    <= 8'h00;
          src_vbus  <= 1'b0;
          snk_vbus  <= 1'b0;
          vconn_en  <= 1'b0;
          orient    <= 1'b0;
          role_ctrl <= tog_byte;
          look_req  <= 1'b1;
          attached  <= 1'b0;
          last_stat <= cc_stat;
        end else if (is_src) begin
          orient    <= (t1 != T_RD);
          hdr_role  <= HDR_SRC;
          rx_det    <= RX_ON;
          vconn_en  <= (t1 == T_RA) || (t2 == T_RA);
          src_vbus  <= 1'b1;
          snk_vbus  <= 1'b0;
          attached  <= 1'b1;
          last_stat <= cc_stat;
        end else if (is_snk) begin
          orient    <= (t1 == T_OPEN);
          role_ctrl <= (t1 != T_OPEN) ? SNK_CC1 : SNK_CC2;
          hdr_role  <= HDR_BASE;
          src_vbus  <= 1'b0;
          snk_vbus  <= 1'b0;
          attached  <= 1'b1;
          last_stat <= cc_stat;
        end else if (is_aud) begin
          last_stat <= cc_stat;
        end else begin
          cc_err <= 1'b1;
        end
      end
    end
  end
endmodule

module typec_cc_attach_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cc_valid,
  input logic [7:0] role_ctrl,
  input logic       orient,
  input logic [7:0] hdr_role,
  input logic [7:0] rx_det,
  input logic       vconn_en,
  input logic       src_vbus,
  input logic       snk_vbus,
  input logic       look_req,
  input logic       attached,
  input logic       cc_err
);
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) cc_err |=> cc_err);
  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_valid |=> ($stable(role_ctrl) && $stable(orient) && $stable(hdr_role) && $stable(rx_det)
                   && $stable(vconn_en) && $stable(src_vbus) && $stable(attached) && !look_req));
  // R3
  detach_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    look_req |-> (role_ctrl[6] && !vconn_en && !src_vbus && !snk_vbus && !orient && !attached && rx_det == 8'h00));
  // R5
  src_attach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_vbus |-> (attached && hdr_role == 8'h0B && rx_det == 8'h21));
  // R8
  hdr_rev_chk: assert property (@(posedge clk) disable iff (!rst_n) hdr_role[1] && hdr_role[7:4] == 4'h0);
  // R10
  look_single_chk: assert property (@(posedge clk) disable iff (!rst_n) look_req |=> !look_req);
endmodule

bind typec_cc_attach typec_cc_attach_chk u_chk (.*);

// File: tb/typec_cc_attach_bench.sv
module typec_cc_attach_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_first = 1'b1;
  logic cc_valid = 1'b0;
  logic [7:0] cc_stat = 8'h00;
  logic [7:0] role_ctrl, hdr_role, rx_det;
  logic orient, ss_sel, vconn_en, src_vbus, snk_vbus, look_req, attached, cc_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] e_role, e_hdr, e_rx, e_last;
  logic e_orient, e_vconn, e_src, e_snk, e_look, e_att, e_err;

  always #5 clk = ~clk;

  typec_cc_attach u_typec_cc_attach (.*);

  function automatic int decode(input logic [1:0] c, input logic snk);
    if (snk) return (c == 0) ? 0 : 3;
    if (c == 1) return 1;
    if (c == 2) return 2;
    return 0;
  endfunction

  // 0 detach, 1 source, 2 sink, 3 audio-detached, 4 error
  function automatic int classify(input logic [7:0] s);
    int a, b;
    a = decode(s[1:0], s[4]);
    b = decode(s[3:2], s[4]);
    if (a == 0 && b == 0) return 0;
    if ((a == 2) != (b == 2)) return 1;
    if ((a == 3 && b == 0) || (b == 3 && a == 0)) return 2;
    if ((a == 1 && b == 0) || (b == 1 && a == 0)) return 3;
    return 4;
  endfunction

  task automatic m_reset();
    e_role = host_first ? 8'h4A : 8'h45;
    e_orient = 0; e_hdr = 8'h02; e_rx = 0; e_vconn = 0; e_src = 0; e_snk = 0;
    e_look = 0; e_att = 0; e_err = 0; e_last = 8'h00;
  endtask

  task automatic m_apply(input logic [7:0] s);
    int a, b;
    e_look = 0;
    if (s == e_last) return;
    a = decode(s[1:0], s[4]);
    b = decode(s[3:2], s[4]);
    case (classify(s))
      0: begin
        e_rx = 0; e_src = 0; e_snk = 0; e_vconn = 0; e_orient = 0; e_att = 0;
        e_role = host_first ? 8'h4A : 8'h45; e_look = 1; e_last = s;
      end
      1: begin
        e_orient = (b == 2); e_hdr = 8'h0B; e_rx = 8'h21; e_vconn = (a == 1 || b == 1);
        e_src = 1; e_snk = 0; e_att = 1; e_last = s;
      end
      2: begin
        e_orient = (a == 0); e_role = (a != 0) ? 8'h0E : 8'h0B; e_hdr = 8'h02;
        e_src = 0; e_snk = 0; e_att = 1; e_last = s;
      end
      3: e_last = s;
      default: e_err = 1;
    endcase
  endtask

  task automatic cmp(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "role_ctrl", role_ctrl, e_role);
    cmp(tag, "orient", orient, e_orient);
    cmp("R9", "ss_sel", ss_sel, !e_orient);
    cmp(tag, "hdr_role", hdr_role, e_hdr);
    cmp(tag, "rx_det", rx_det, e_rx);
    cmp(tag, "vconn_en", vconn_en, e_vconn);
    cmp(tag, "src_vbus", src_vbus, e_src);
    cmp(tag, "snk_vbus", snk_vbus, e_snk);
    cmp(tag, "look_req", look_req, e_look);
    cmp(tag, "attached", attached, e_att);
    cmp(tag, "cc_err", cc_err, e_err);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cc_valid = 0;
    @(negedge clk); @(negedge clk);
    m_reset();
    check_all("R1");
    rst_n = 1;
  endtask

  task automatic send(input logic [7:0] s, input string tag);
    @(negedge clk);
    cc_stat = s; cc_valid = 1;
    m_apply(s);
    @(negedge clk);
    cc_valid = 0;
    check_all(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      e_look = 0;
      check_all("R13");
    end
  endtask

  function automatic string tag_of(input logic [7:0] s);
    if (s == e_last) return "R10";
    case (classify(s))
      0: return "R3";
      1: return "R5";
      2: return "R7";
      3: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    host_first = 1;
    do_reset();
    send(8'h02, "R5");          // CC1 Rd, CC2 open: source, CC1, no VCONN (R6)
    send(8'h09, "R6");          // CC1 Ra, CC2 Rd: source, CC2, VCONN on
    send(8'h09, "R10");         // repeat: no action
    idle(2);
    host_first = 0;
    send(8'h00, "R4");          // detach, device-first toggling 0x45
    idle(1);
    send(8'hF8, "R2");          // upper bits ignored; sink flag, CC2 Rp
    send(8'h13, "R7");          // sink, CC1 Rp 3.0
    send(8'h1F, "R12");         // both Rp: error, nothing else
    send(8'h01, "R11");         // CC1 Ra, CC2 open: audio detached
    send(8'h0C, "R2");          // source reading: CC1 open, CC2 code 3 -> open => detach
    send(8'h05, "R12");         // Ra + Ra
    host_first = 1;
    do_reset();
    send(8'h08, "R5");          // CC2 Rd
    send(8'h20, "R3");          // toggling flag only: detach, 0x4A
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) host_first = $urandom_range(0, 1);
      s = ($urandom_range(0, 4) == 0) ? e_last : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) s = {2'b00, s[5:0] & 6'h1F};
      send(s, tag_of(s));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
      if ($urandom_range(0, 199) == 0) do_reset();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule